// File: doc/BRIEF.md
# Register-Stack Arithmetic Unit

This block holds eight integer registers organised as a circular stack with a rotating top pointer. Operands are named relative to the current top: ST(0) is the top and ST(i) is the entry i places below it. A caller issues one command per cycle by raising `cmdValid`. A command can push a value, read an entry back, run an add, subtract, reversed subtract or multiply between ST(0) and ST(i), or compare the two. Each of these except the push can also pop the top once it is done.

In the arithmetic forms, one of the two operands is both a source and the destination. `cmdDestDeep` picks ST(i) as the destination; when it is low, ST(0) is the destination. Each physical slot has an occupancy tag. A push onto an occupied slot is refused with an overflow indication, and reading or popping an empty slot is refused with an underflow indication. The one-cycle response carries the result, the compare flags, the error bits and the current top pointer.

Top module: `regstack_alu`

## Requirements
- R1: After reset, `topPtr` is 0, every slot is empty and `rspValid` is low.
- R2: Opcode 0 (load) moves the top down by one, modulo 8, and writes `cmdData` into the new ST(0). The response echoes the value.
- R3: A load whose target slot, physical (top-1) mod 8, is occupied raises `rspOverflow`. The stack contents and the top pointer are left unchanged.
- R4: ST(i) names physical slot (top+i) mod 8. Opcode 1 (store) returns ST(i) on `rspData` and writes nothing.
- R5: Opcode 2 (add) and opcode 5 (multiply, low DATA_W bits) combine ST(0) and ST(i). The result is written to ST(i) when `cmdDestDeep` is 1 and to ST(0) otherwise, and it is also returned on `rspData`.
- R6: Opcode 3 (subtract) computes destination minus other operand. Opcode 4 (reversed subtract) computes other operand minus destination and writes to the same destination as opcode 3.
- R7: When `cmdPop` is set on a store, arithmetic or compare command that succeeds, the operation completes first. The top slot is then emptied and the top moves up by one, modulo 8, so a result written to ST(i) becomes ST(i-1).
- R8: Opcode 6 (compare) sets exactly one of `rspLess`, `rspEqual` and `rspGreater` from the signed comparison of ST(0) against ST(i). It writes no stack entry and returns zero data.
- R9: A store, arithmetic or compare command raises `rspUnderflow` and changes nothing if it reads an empty slot, or if it pops while ST(0) is empty.
- R10: `rspValid` is high in exactly the cycle after each accepted command. On an error response, the data and flag outputs are zero.
- R11: Opcodes 7 to 15 do nothing and return a response with zero data and no flags. `cmdPop` has no effect on a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 4 | Opcode |
| cmdIdx | input | 3 | Stack-relative index i |
| cmdDestDeep | input | 1 | Arithmetic destination is ST(i) rather than ST(0) |
| cmdPop | input | 1 | Pop after the operation |
| cmdData | input | DATA_W | Value to push |
| rspValid | output | 1 | Response strobe |
| rspData | output | DATA_W | Result, stored value or pushed value |
| rspLess | output | 1 | Compare: ST(0) < ST(i) |
| rspEqual | output | 1 | Compare: ST(0) = ST(i) |
| rspGreater | output | 1 | Compare: ST(0) > ST(i) |
| rspOverflow | output | 1 | Push refused |
| rspUnderflow | output | 1 | Read or pop of an empty slot refused |
| topPtr | output | 3 | Physical index of ST(0) |

## Verification
The assertions assume that a command is fully presented whenever `cmdValid` is high. They also assume that the command inputs, including the index and the pop bit, never carry X, because the occupancy checks that guard the state-holding properties depend on them. The stimulus drives every command field on the falling edge, keeps it steady through the next rising edge, and drives all fields to defined values even in idle cycles. The random phase varies the opcode, index, destination side and pop bit across the full legal range, so the top pointer wraps many times and the stack regularly fills and empties.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  localparam int STACK_DEPTH = 8;
  localparam int PTR_W = $clog2(STACK_DEPTH);

  localparam logic [3:0] OPC_LOAD  = 4'd0;
  localparam logic [3:0] OPC_STORE = 4'd1;
  localparam logic [3:0] OPC_ADD   = 4'd2;
  localparam logic [3:0] OPC_SUB   = 4'd3;
  localparam logic [3:0] OPC_SUBR  = 4'd4;
  localparam logic [3:0] OPC_MUL   = 4'd5;
  localparam logic [3:0] OPC_CMP   = 4'd6;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_MUL} aluSel_e;

  typedef struct packed {
    logic             rspEn;
    logic             wrEn;
    logic             wrLoad;
    logic [PTR_W-1:0] destPhys;
    logic [PTR_W-1:0] othPhys;
    aluSel_e          aluSel;
    logic             swap;
    logic             cmpEn;
    logic             storeEn;
    logic             ovf;
    logic             unf;
  } strobe_t;
endpackage

// File: rtl/rsa_ctrl.sv
module rsa_ctrl
  import rsa_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [3:0]       cmdOp,
  input  logic [PTR_W-1:0] cmdIdx,
  input  logic             cmdDestDeep,
  input  logic             cmdPop,
  output strobe_t          stb,
  output logic [PTR_W-1:0] topPtr
);
  logic [STACK_DEPTH-1:0] tagQ;
  logic [PTR_W-1:0] topQ;
  logic [PTR_W-1:0] pushSlot, idxPhys;
  logic isLoad, isStore, isArith, isCmp, readsPair, popping;
  logic needTop, needIdx, ovf, unf, ok, doPush, doPop, deepDest;

  assign pushSlot = topQ - PTR_W'(1);
  assign idxPhys  = topQ + cmdIdx;

  always_comb begin
    isLoad    = (cmdOp == OPC_LOAD);
    isStore   = (cmdOp == OPC_STORE);
    isArith   = (cmdOp == OPC_ADD) || (cmdOp == OPC_SUB) ||
                (cmdOp == OPC_SUBR) || (cmdOp == OPC_MUL);
    isCmp     = (cmdOp == OPC_CMP);
    readsPair = isArith || isCmp;
    popping   = cmdPop && (isStore || readsPair);
    needTop   = readsPair || popping;
    needIdx   = isStore || readsPair;
    ovf       = cmdValid && isLoad && tagQ[pushSlot];
    unf       = cmdValid && ((needTop && !tagQ[topQ]) || (needIdx && !tagQ[idxPhys]));
    ok        = cmdValid && !ovf && !unf;
    doPush    = ok && isLoad;
    doPop     = ok && popping;
    deepDest  = isArith && cmdDestDeep;
  end

  always_comb begin
    stb.rspEn    = cmdValid;
    stb.wrEn     = ok && (isLoad || isArith);
    stb.wrLoad   = isLoad;
    stb.destPhys = isLoad ? pushSlot : (deepDest ? idxPhys : topQ);
    stb.othPhys  = deepDest ? topQ : idxPhys;
    unique case (cmdOp)
      OPC_SUB, OPC_SUBR: stb.aluSel = ALU_SUB;
      OPC_MUL:           stb.aluSel = ALU_MUL;
      default:           stb.aluSel = ALU_ADD;
    endcase
    stb.swap    = (cmdOp == OPC_SUBR);
    stb.cmpEn   = ok && isCmp;
    stb.storeEn = ok && isStore;
    stb.ovf     = ovf;
    stb.unf     = unf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagQ <= '0;
      topQ <= '0;
    end else if (doPush) begin
      tagQ[pushSlot] <= 1'b1;
      topQ           <= pushSlot;
    end else if (doPop) begin
      tagQ[topQ] <= 1'b0;
      topQ       <= topQ + PTR_W'(1);
    end
  end

  assign topPtr = topQ;

  // R3
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ovf |=> ($stable(topQ) && $stable(tagQ)));
  // R9
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.unf |=> ($stable(topQ) && $stable(tagQ)));
  // R2
  push_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    doPush |=> (topQ == $past(topQ) - PTR_W'(1)) && tagQ[topQ]);
  // R7
  pop_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    doPop |=> (topQ == $past(topQ) + PTR_W'(1)) && !tagQ[$past(topQ)]);
endmodule

// File: rtl/rsa_dpath.sv
module rsa_dpath
  import rsa_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] cmdData,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspLess,
  output logic              rspEqual,
  output logic              rspGreater,
  output logic              rspOverflow,
  output logic              rspUnderflow
);
  logic [DATA_W-1:0] regFile [STACK_DEPTH];
  logic [DATA_W-1:0] opDest, opOth, aluA, aluB, aluRes, wrVal;

  assign opDest = regFile[stb.destPhys];
  assign opOth  = regFile[stb.othPhys];
  assign aluA   = stb.swap ? opOth : opDest;
  assign aluB   = stb.swap ? opDest : opOth;

  always_comb begin
    unique case (stb.aluSel)
      ALU_SUB: aluRes = aluA - aluB;
      ALU_MUL: aluRes = aluA * aluB;
      default: aluRes = aluA + aluB;
    endcase
  end

  assign wrVal = stb.wrLoad ? cmdData : aluRes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < STACK_DEPTH; k++) regFile[k] <= '0;
    end else if (stb.wrEn) begin
      regFile[stb.destPhys] <= wrVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspData      <= '0;
      rspLess      <= 1'b0;
      rspEqual     <= 1'b0;
      rspGreater   <= 1'b0;
      rspOverflow  <= 1'b0;
      rspUnderflow <= 1'b0;
    end else begin
      rspValid     <= stb.rspEn;
      rspData      <= stb.wrEn ? wrVal : (stb.storeEn ? opOth : '0);
      rspLess      <= stb.cmpEn && ($signed(opDest) <  $signed(opOth));
      rspEqual     <= stb.cmpEn && (opDest == opOth);
      rspGreater   <= stb.cmpEn && ($signed(opDest) >  $signed(opOth));
      rspOverflow  <= stb.ovf;
      rspUnderflow <= stb.unf;
    end
  end

  // R10
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rspEn |=> rspValid);
  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rspEn |=> !rspValid);
  // R8
  cmp_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.cmpEn |=> ($countones({rspLess, rspEqual, rspGreater}) == 1) && (rspData == '0));
  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspOverflow || rspUnderflow) |-> (rspData == '0) && !(rspLess || rspEqual || rspGreater));
endmodule

// File: rtl/regstack_alu.sv
module regstack_alu
  import rsa_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [2:0]        cmdIdx,
  input  logic              cmdDestDeep,
  input  logic              cmdPop,
  input  logic [DATA_W-1:0] cmdData,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspLess,
  output logic              rspEqual,
  output logic              rspGreater,
  output logic              rspOverflow,
  output logic              rspUnderflow,
  output logic [2:0]        topPtr
);
  strobe_t stb;

  rsa_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdIdx(cmdIdx), .cmdDestDeep(cmdDestDeep), .cmdPop(cmdPop),
    .stb(stb), .topPtr(topPtr)
  );

  rsa_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdData(cmdData),
    .rspValid(rspValid), .rspData(rspData), .rspLess(rspLess),
    .rspEqual(rspEqual), .rspGreater(rspGreater),
    .rspOverflow(rspOverflow), .rspUnderflow(rspUnderflow)
  );
endmodule

// File: tb/sim_regstack_alu.sv
module sim_regstack_alu;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [3:0] cmdOp = '0;
  logic [2:0] cmdIdx = '0;
  logic cmdDestDeep = 1'b0;
  logic cmdPop = 1'b0;
  logic [W-1:0] cmdData = '0;
  logic rspValid, rspLess, rspEqual, rspGreater, rspOverflow, rspUnderflow;
  logic [W-1:0] rspData;
  logic [2:0] topPtr;

  always #4 clk = ~clk;

  regstack_alu #(.DATA_W(W)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdIdx(cmdIdx),
    .cmdDestDeep(cmdDestDeep), .cmdPop(cmdPop), .cmdData(cmdData),
    .rspValid(rspValid), .rspData(rspData), .rspLess(rspLess), .rspEqual(rspEqual),
    .rspGreater(rspGreater), .rspOverflow(rspOverflow), .rspUnderflow(rspUnderflow),
    .topPtr(topPtr)
  );

  int total = 0;
  int bad = 0;

  // behavioural reference state
  logic [W-1:0] mVal [8];
  bit mTag [8];
  int mTop = 0;

  bit eValid = 0, eLt = 0, eEq = 0, eGt = 0, eOvf = 0, eUnf = 0;
  logic [W-1:0] eData = '0;
  int eTop = 0;
  string eTag = "R1";

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkOutputs();
    chk("R10", "rspValid", rspValid, eValid);
    chk(eTag, "rspData", rspData, eData);
    chk("R8", "rspLess", rspLess, eLt);
    chk("R8", "rspEqual", rspEqual, eEq);
    chk("R8", "rspGreater", rspGreater, eGt);
    chk("R3", "rspOverflow", rspOverflow, eOvf);
    chk("R9", "rspUnderflow", rspUnderflow, eUnf);
    chk(eTag, "topPtr", topPtr, eTop);
  endtask

  task automatic model(input bit v, input logic [3:0] op, input int idx, input bit deep,
                       input bit pop, input logic [W-1:0] d);
    int sTop, sI, sPush, dst, oth;
    bit isLoad, isStore, isArith, isCmp, popping, needTop;
    logic [W-1:0] a, b, r;
    logic [2*W-1:0] p;
    eValid = v; eData = '0; eLt = 0; eEq = 0; eGt = 0; eOvf = 0; eUnf = 0;
    eTag = "R10";
    if (v) begin
      sTop = mTop; sI = (mTop + idx) % 8; sPush = (mTop + 7) % 8;
      isLoad = (op == 0); isStore = (op == 1); isCmp = (op == 6);
      isArith = (op >= 2 && op <= 5);
      popping = pop && (isStore || isArith || isCmp);
      needTop = isArith || isCmp || popping;
      if (isLoad) begin
        if (mTag[sPush]) begin eOvf = 1; eTag = "R3"; end
        else begin
          mVal[sPush] = d; mTag[sPush] = 1; mTop = sPush; eData = d; eTag = "R2";
        end
      end else if (isStore || isArith || isCmp) begin
        if ((needTop && !mTag[sTop]) || !mTag[sI]) begin eUnf = 1; eTag = "R9"; end
        else begin
          dst = (isArith && deep) ? sI : sTop;
          oth = (isArith && deep) ? sTop : sI;
          a = mVal[dst]; b = mVal[oth]; r = '0;
          case (op)
            4'd1: begin eData = mVal[sI]; eTag = "R4"; end
            4'd2: begin r = a + b; eTag = "R5"; end
            4'd3: begin r = a - b; eTag = "R6"; end
            4'd4: begin r = b - a; eTag = "R6"; end
            4'd5: begin p = a * b; r = p[W-1:0]; eTag = "R5"; end
            default: begin
              eLt = $signed(mVal[sTop]) < $signed(mVal[sI]);
              eEq = mVal[sTop] == mVal[sI];
              eGt = $signed(mVal[sTop]) > $signed(mVal[sI]);
              eTag = "R8";
            end
          endcase
          if (isArith) begin mVal[dst] = r; eData = r; end
          if (popping) begin
            mTag[sTop] = 0; mTop = (mTop + 1) % 8; eTag = "R7";
          end
        end
      end else eTag = "R11";
    end
    eTop = mTop;
  endtask

  task automatic step(input bit v, input logic [3:0] op, input int idx, input bit deep,
                      input bit pop, input logic [W-1:0] d);
    @(negedge clk);
    checkOutputs();
    cmdValid = v; cmdOp = op; cmdIdx = idx[2:0]; cmdDestDeep = deep;
    cmdPop = pop; cmdData = d;
    model(v, op, idx, deep, pop, d);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) begin mVal[k] = '0; mTag[k] = 0; end
    repeat (3) @(negedge clk);
    chk("R1", "rspValid in reset", rspValid, 0);
    chk("R1", "topPtr in reset", topPtr, 0);
    rstN = 1'b1;
    // R1 / R9: store from an empty stack underflows
    step(1, 4'd1, 0, 0, 0, '0);
    // R2: fill all eight slots, wrapping the top
    for (int k = 1; k <= 8; k++) step(1, 4'd0, 0, 0, 0, W'(k * 10));
    // R3: ninth push overflows
    step(1, 4'd0, 0, 0, 0, 16'h0090);
    // R11: pop flag ignored on a (refused) load, then a plain nop
    step(1, 4'd0, 0, 0, 1, 16'h0091);
    step(1, 4'd9, 2, 1, 1, 16'h1234);
    // R4: relative addressing
    step(1, 4'd1, 3, 0, 0, '0);
    step(1, 4'd1, 7, 0, 0, '0);
    // R5: add into ST(0), multiply into ST(i)
    step(1, 4'd2, 1, 0, 0, '0);
    step(1, 4'd5, 3, 1, 0, '0);
    // R6: normal and reversed subtract, both destinations
    step(1, 4'd3, 2, 1, 0, '0);
    step(1, 4'd4, 1, 0, 0, '0);
    step(1, 4'd4, 2, 1, 0, '0);
    // R8: compares, including an entry against itself
    step(1, 4'd6, 1, 0, 0, '0);
    step(1, 4'd6, 0, 0, 0, '0);
    step(1, 4'd6, 2, 1, 0, '0);
    // R7: popping add into ST(1), result read back as ST(0)
    step(1, 4'd2, 1, 1, 1, '0);
    step(1, 4'd1, 0, 0, 0, '0);
    // R7 / R9: drain with popping stores, then pop past empty
    for (int k = 0; k < 8; k++) step(1, 4'd1, 0, 0, 1, '0);
    step(0, 4'd0, 0, 0, 0, '0);
    // R9: a read of a deeper empty slot
    step(1, 4'd0, 0, 0, 0, 16'hFFFE);
    step(1, 4'd2, 1, 0, 0, '0);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] op;
      int r;
      r = $urandom_range(0, 99);
      if (r < 30) op = 4'd0;
      else if (r < 95) op = 4'($urandom_range(1, 6));
      else op = 4'($urandom_range(7, 15));
      step($urandom_range(0, 9) != 0, op, $urandom_range(0, 7), 1'($urandom),
           ($urandom_range(0, 3) == 0), W'($urandom));
    end
    step(0, 4'd0, 0, 0, 0, '0);
    @(negedge clk);
    checkOutputs();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule